// File: doc/BRIEF.md
# Packed Rounding Multiply-High Unit

This block multiplies two 64-bit packed operands lane by lane and returns one lane-width slice of each product. Configured for narrow lanes it treats each operand as four 16-bit elements. Configured for wide lanes it treats each operand as two 32-bit elements. Each product is formed at full double width from sign-extended or zero-extended elements, and the upper half is returned. An optional round-to-nearest bias of half an output LSB can be applied before the upper half is taken. A separate low-half mode returns the lower 32 bits of each wide product.

The result is truncated to lane width and never saturated. A request is presented with a one-cycle valid strobe. The packed result appears two clock cycles later with its own valid strobe. The pipeline accepts a new request every cycle. Between results, the output register keeps its last value.

Top module: `pmulh_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `result` is all zeros.
- R2: A request accepted with `in_valid` high at a rising edge produces `out_valid` high for exactly one cycle, two rising edges later. Back-to-back requests produce back-to-back results in issue order.
- R3: Narrow mode without rounding (`wide_mode`=0, `low_mode`=0, `round_mode`=0): lane i, which is bits [16i+15:16i] for i = 0..3, returns bits [31:16] of the 32-bit product of that lane's operands. The operands are sign-extended when `signed_mode`=1 and zero-extended when it is 0.
- R4: Narrow mode with rounding (`round_mode`=1): 0x8000 is added to each 32-bit lane product, modulo 2^32, before bits [31:16] are taken.
- R5: Wide mode without rounding (`wide_mode`=1, `low_mode`=0): lane j, which is bits [32j+31:32j] for j = 0..1, returns bits [63:32] of the 64-bit product. The operands are extended as selected by `signed_mode`.
- R6: Wide mode with rounding: 2^31 is added to each 64-bit lane product, modulo 2^64, before bits [63:32] are taken.
- R7: Low-half mode (`wide_mode`=1, `low_mode`=1): each 32-bit lane returns bits [31:0] of its product. `signed_mode` and `round_mode` have no effect in this mode.
- R8: Illegal combination (`low_mode`=1, `wide_mode`=0): the whole 64-bit result is zero.
- R9: While `out_valid` is low, `result` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; operands and mode bits are sampled when high |
| op_a | input | 64 | Packed first operand |
| op_b | input | 64 | Packed second operand |
| wide_mode | input | 1 | 0 = four 16-bit lanes, 1 = two 32-bit lanes |
| signed_mode | input | 1 | 1 = signed (two's complement) elements, 0 = unsigned |
| round_mode | input | 1 | 1 = add half an output LSB before taking the high half |
| low_mode | input | 1 | 1 = return the low half of wide products |
| out_valid | output | 1 | High for one cycle when `result` carries a new value |
| result | output | 64 | Packed result |

## Verification
The bench targets the extreme products. In signed 16-bit mode, -32768 times -32768 must give 0x4000. In unsigned mode, 0xFFFF times 0xFFFF must give 0xFFFE. Both cases are checked with and without rounding, so a design that mishandles extension or lets the bias carry into the wrong bit gives a visibly wrong lane.

Rounding is probed with products whose bit just below the kept half is set and with products where it is clear. One signed case makes the bias cancel a negative product to exactly zero. A design that adds the bias after the shift, or drops it, fails these cases. Other cases use 1 times 0x80000000 and 2 times 0x80000000 in both signed and unsigned form; a design that takes the wide high half from the wrong bits, or ignores signedness there, gives all-ones or zero in the wrong lane.

Low-half mode, the illegal narrow-plus-low combination, back-to-back issue, and the hold of `result` between strobes are each checked at the ports. Patterns across all modes are also compared with a bench-side model.

// File: rtl/pmulh_pkg.sv
`timescale 1ns/1ps
// Shared types for the packed multiply-high unit.
// Holds the mode bits that travel down the pipeline behind the products.
package pmulh_pkg;

    // Mode bits still needed after the product stage. Signedness is
    // consumed while the products are formed, so it is not carried here.
    typedef struct packed {
        logic wide;   // 1 = 32-bit lanes
        logic rnd;    // 1 = add half-LSB bias before taking the high half
        logic lo;     // 1 = return the low half of wide products
    } pmulh_ctrl_t;

endpackage

// File: rtl/pmulh_product_stage.sv
`timescale 1ns/1ps
// Stage 1 of the multiply-high pipeline.
// Forms every narrow-lane and wide-lane product in parallel and registers
// them together with the mode bits and a valid flag.
// Assumes DATA_W is a multiple of WIDE_W, and WIDE_W of NARROW_W.
// For each narrow lane only bits [2*NARROW_W-1 : NARROW_W-1] are kept: the
// high half plus the guard bit that decides rounding. Wide lanes keep the
// full product because the low-half mode needs its lower bits.
module pmulh_product_stage
    import pmulh_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    localparam int N_NARROW = DATA_W / NARROW_W,
    localparam int N_WIDE   = DATA_W / WIDE_W
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    input  logic [DATA_W-1:0]                      op_a,
    input  logic [DATA_W-1:0]                      op_b,
    input  logic                                   sgn,
    input  pmulh_ctrl_t                            ctrl_in,
    output logic                                   s1_valid,
    output pmulh_ctrl_t                            ctrl_q,
    output logic [N_NARROW-1:0][NARROW_W:0]        narrow_q,
    output logic [N_WIDE-1:0][2*WIDE_W-1:0]        wide_q
);

    logic [N_NARROW-1:0][NARROW_W:0]   narrow_d;
    logic [N_WIDE-1:0][2*WIDE_W-1:0]   wide_d;

    // Narrow lanes: extend by one bit, multiply, keep the high half plus the guard bit.
    for (genvar g = 0; g < N_NARROW; g++) begin : g_narrow
        logic signed [NARROW_W:0] xa;
        logic signed [NARROW_W:0] xb;
        assign xa = {sgn & op_a[g*NARROW_W+NARROW_W-1], op_a[g*NARROW_W +: NARROW_W]};
        assign xb = {sgn & op_b[g*NARROW_W+NARROW_W-1], op_b[g*NARROW_W +: NARROW_W]};
        assign narrow_d[g] = (NARROW_W+1)'(((2*NARROW_W)'(xa) * (2*NARROW_W)'(xb)) >> (NARROW_W-1));
    end

    // Wide lanes: extend by one bit and keep the full double-width product.
    for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
        logic signed [WIDE_W:0] xa;
        logic signed [WIDE_W:0] xb;
        assign xa = {sgn & op_a[g*WIDE_W+WIDE_W-1], op_a[g*WIDE_W +: WIDE_W]};
        assign xb = {sgn & op_b[g*WIDE_W+WIDE_W-1], op_b[g*WIDE_W +: WIDE_W]};
        assign wide_d[g] = (2*WIDE_W)'(xa) * (2*WIDE_W)'(xb);
    end

    // Capture the products and mode bits on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            ctrl_q   <= '0;
            narrow_q <= '0;
            wide_q   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                ctrl_q   <= ctrl_in;
                narrow_q <= narrow_d;
                wide_q   <= wide_d;
            end
        end
    end

endmodule

// File: rtl/pmulh_round_stage.sv
`timescale 1ns/1ps
// Stage 2 of the multiply-high pipeline.
// Applies the optional half-LSB rounding, selects the high or low half of
// each lane, and registers the packed result and valid flag.
// Adding 2^(k-1) and shifting right by k equals the high half plus the guard
// bit, so rounding is done as a k-bit increment of the kept half.
// Assumes the product registers were written by pmulh_product_stage.
module pmulh_round_stage
    import pmulh_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    localparam int N_NARROW = DATA_W / NARROW_W,
    localparam int N_WIDE   = DATA_W / WIDE_W
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   s1_valid,
    input  pmulh_ctrl_t                            ctrl_q,
    input  logic [N_NARROW-1:0][NARROW_W:0]        narrow_q,
    input  logic [N_WIDE-1:0][2*WIDE_W-1:0]        wide_q,
    output logic                                   out_valid,
    output logic [DATA_W-1:0]                      result
);

    logic [DATA_W-1:0] narrow_vec;
    logic [DATA_W-1:0] wide_hi_vec;
    logic [DATA_W-1:0] wide_lo_vec;
    logic [DATA_W-1:0] result_d;

    // Narrow lanes: high half, incremented by the guard bit when rounding.
    for (genvar g = 0; g < N_NARROW; g++) begin : g_narrow
        assign narrow_vec[g*NARROW_W +: NARROW_W] =
            narrow_q[g][NARROW_W:1] + NARROW_W'(ctrl_q.rnd & narrow_q[g][0]);
    end

    // Wide lanes: rounded high half and unrounded low half.
    for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
        assign wide_hi_vec[g*WIDE_W +: WIDE_W] =
            wide_q[g][2*WIDE_W-1:WIDE_W] + WIDE_W'(ctrl_q.rnd & wide_q[g][WIDE_W-1]);
        assign wide_lo_vec[g*WIDE_W +: WIDE_W] = wide_q[g][WIDE_W-1:0];
    end

    // Pick the result for the mode; low half with narrow lanes gives zero.
    always_comb begin
        if (ctrl_q.lo)
            result_d = ctrl_q.wide ? wide_lo_vec : '0;
        else
            result_d = ctrl_q.wide ? wide_hi_vec : narrow_vec;
    end

    // Register the result; it changes only when a stage-1 entry is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid)
                result <= result_d;
        end
    end

    // R8: narrow lanes with the low-half bit set give an all-zero result.
    assert_illegal_lo_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && ctrl_q.lo && !ctrl_q.wide) |=> (result == '0));

    // R7: low-half mode passes lane 0's low product bits through unchanged.
    assert_low_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && ctrl_q.lo && ctrl_q.wide)
        |=> (result[WIDE_W-1:0] == $past(wide_q[0][WIDE_W-1:0])));

    // R4: a clear guard bit means rounding leaves narrow lane 0 unchanged.
    assert_round_no_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !ctrl_q.wide && !ctrl_q.lo && ctrl_q.rnd && !narrow_q[0][0])
        |=> (result[NARROW_W-1:0] == $past(narrow_q[0][NARROW_W:1])));

endmodule

// File: rtl/pmulh_unit.sv
`timescale 1ns/1ps
// Packed rounding multiply-high unit, top level.
// Two-stage pipeline: the product stage, then the round/select stage.
// One request per cycle; the result follows two cycles after in_valid.
// Assumes the mode inputs are stable on the cycle in_valid is high.
module pmulh_unit
    import pmulh_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              wide_mode,
    input  logic              signed_mode,
    input  logic              round_mode,
    input  logic              low_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    localparam int N_NARROW = DATA_W / NARROW_W;
    localparam int N_WIDE   = DATA_W / WIDE_W;

    pmulh_ctrl_t                         ctrl_in;
    pmulh_ctrl_t                         ctrl_q;
    logic                                s1_valid;
    logic [N_NARROW-1:0][NARROW_W:0]     narrow_q;
    logic [N_WIDE-1:0][2*WIDE_W-1:0]     wide_q;

    // Pack the mode inputs that stage 2 still needs.
    assign ctrl_in = '{wide: wide_mode, rnd: round_mode, lo: low_mode};

    pmulh_product_stage #(
        .DATA_W(DATA_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)
    ) i_product (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .sgn(signed_mode), .ctrl_in(ctrl_in),
        .s1_valid(s1_valid), .ctrl_q(ctrl_q), .narrow_q(narrow_q), .wide_q(wide_q)
    );

    pmulh_round_stage #(
        .DATA_W(DATA_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)
    ) i_round (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .ctrl_q(ctrl_q),
        .narrow_q(narrow_q), .wide_q(wide_q),
        .out_valid(out_valid), .result(result)
    );

    // R2: every output strobe traces back to a request two edges earlier.
    assert_latency_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R9: without an output strobe the result does not move.
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(result));

endmodule

// File: tb/test_pmulh_unit.sv
`timescale 1ns/1ps
// Directed bench for pmulh_unit: one task per scenario, each checking its results.
module test_pmulh_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        wide_mode = 1'b0;
    logic        signed_mode = 1'b0;
    logic        round_mode = 1'b0;
    logic        low_mode = 1'b0;
    logic        out_valid;
    logic [63:0] result;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    pmulh_unit i_pmulh_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .wide_mode(wide_mode),
        .signed_mode(signed_mode), .round_mode(round_mode), .low_mode(low_mode),
        .out_valid(out_valid), .result(result)
    );

    // Compare one value and report a mismatch.
    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Bench-side model written from the requirements.
    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic w, input logic s,
                                          input logic r, input logic l);
        logic [63:0] res = '0;
        if (l) begin
            if (w) begin
                for (int j = 0; j < 2; j++) begin
                    logic [63:0] x = s ? {{32{a[32*j+31]}}, a[32*j +: 32]} : {32'd0, a[32*j +: 32]};
                    logic [63:0] y = s ? {{32{b[32*j+31]}}, b[32*j +: 32]} : {32'd0, b[32*j +: 32]};
                    logic [63:0] p = x * y;
                    res[32*j +: 32] = p[31:0];
                end
            end
        end else if (w) begin
            for (int j = 0; j < 2; j++) begin
                logic [63:0] x = s ? {{32{a[32*j+31]}}, a[32*j +: 32]} : {32'd0, a[32*j +: 32]};
                logic [63:0] y = s ? {{32{b[32*j+31]}}, b[32*j +: 32]} : {32'd0, b[32*j +: 32]};
                logic [63:0] p = x * y + (r ? 64'h8000_0000 : 64'd0);
                res[32*j +: 32] = p[63:32];
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                logic [31:0] x = s ? {{16{a[16*i+15]}}, a[16*i +: 16]} : {16'd0, a[16*i +: 16]};
                logic [31:0] y = s ? {{16{b[16*i+15]}}, b[16*i +: 16]} : {16'd0, b[16*i +: 16]};
                logic [31:0] p = x * y + (r ? 32'h8000 : 32'd0);
                res[16*i +: 16] = p[31:16];
            end
        end
        return res;
    endfunction

    // Issue one request, check the strobe and value, then check the hold (R2, R9).
    task automatic run_one(input string tag, input logic [63:0] a, input logic [63:0] b,
                           input logic w, input logic s, input logic r, input logic l,
                           input logic [63:0] exp);
        @(negedge clk);
        op_a = a; op_b = b; wide_mode = w; signed_mode = s; round_mode = r; low_mode = l;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        op_a = ~a; op_b = ~b;
        @(negedge clk);
        check({tag, " R2 valid"}, {63'd0, out_valid}, 64'd1);
        check(tag, result, exp);
        @(negedge clk);
        check({tag, " R2 single strobe"}, {63'd0, out_valid}, 64'd0);
        check({tag, " R9 hold"}, result, exp);
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
        check("R1 result in reset", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {63'd0, out_valid}, 64'd0);
        check("R1 result after reset", result, 64'd0);
    endtask

    // R3 / R4: extreme narrow products in both rounding settings.
    task automatic t_narrow_extremes();
        run_one("R3 s16 -32768^2",      64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 0, 1, 0, 0, 64'h4000_4000_4000_4000);
        run_one("R4 s16 -32768^2 rnd",  64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 0, 1, 1, 0, 64'h4000_4000_4000_4000);
        run_one("R3 u16 FFFF^2",        64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 64'hFFFE_FFFE_FFFE_FFFE);
        run_one("R4 u16 FFFF^2 rnd",    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1, 0, 64'hFFFE_FFFE_FFFE_FFFE);
        run_one("R3 s16 -1*-1",         64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, 0, 64'h0000_0000_0000_0000);
    endtask

    // R3 / R4: guard-bit set and clear, signed and unsigned.
    task automatic t_narrow_rounding();
        run_one("R3 u16 mix",     64'h0003_0100_7FFF_0001, 64'h5555_0100_8000_8000, 0, 0, 0, 0, 64'h0000_0001_3FFF_0000);
        run_one("R4 u16 mix rnd", 64'h0003_0100_7FFF_0001, 64'h5555_0100_8000_8000, 0, 0, 1, 0, 64'h0001_0001_4000_0001);
        run_one("R3 s16 mix",     64'h0003_0100_7FFF_0001, 64'h5555_0100_8000_8000, 0, 1, 0, 0, 64'h0000_0001_C000_FFFF);
        run_one("R4 s16 mix rnd", 64'h0003_0100_7FFF_0001, 64'h5555_0100_8000_8000, 0, 1, 1, 0, 64'h0001_0001_C001_0000);
    endtask

    // R5 / R6: wide-lane high half.
    task automatic t_wide_high();
        run_one("R5 s32 min^2",     64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 1, 1, 0, 0, 64'h4000_0000_4000_0000);
        run_one("R5 u32 max^2",     64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 0, 64'hFFFF_FFFE_FFFF_FFFE);
        run_one("R6 u32 max^2 rnd", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 1, 0, 64'hFFFF_FFFE_FFFF_FFFE);
        run_one("R5 s32 -1*-1",     64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, 0, 64'h0000_0000_0000_0000);
        run_one("R5 u32 guard",     64'h0000_0002_0000_0001, 64'h8000_0000_8000_0000, 1, 0, 0, 0, 64'h0000_0001_0000_0000);
        run_one("R6 u32 guard rnd", 64'h0000_0002_0000_0001, 64'h8000_0000_8000_0000, 1, 0, 1, 0, 64'h0000_0001_0000_0001);
        run_one("R5 s32 guard",     64'h0000_0002_0000_0001, 64'h8000_0000_8000_0000, 1, 1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        run_one("R6 s32 guard rnd", 64'h0000_0002_0000_0001, 64'h8000_0000_8000_0000, 1, 1, 1, 0, 64'hFFFF_FFFF_0000_0000);
    endtask

    // R7 / R8: low-half mode and the illegal narrow-plus-low combination.
    task automatic t_low_half();
        run_one("R7 lo unsigned",     64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 1, 64'h0000_0001_0000_0001);
        run_one("R7 lo signed rnd",   64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1, 1, 64'h0000_0001_0000_0001);
        run_one("R7 lo carry out",    64'h1234_5678_0001_0000, 64'h0000_0010_0001_0000, 1, 0, 0, 1, 64'h2345_6780_0000_0000);
        run_one("R8 lo narrow",       64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 1, 64'h0000_0000_0000_0000);
        run_one("R8 lo narrow s rnd", 64'h1234_5678_9ABC_DEF0, 64'h7FFF_8000_0101_FFFF, 0, 1, 1, 1, 64'h0000_0000_0000_0000);
    endtask

    // R2: back-to-back requests come out in order on consecutive cycles.
    task automatic t_back_to_back();
        logic [63:0] a1 = 64'h0003_0100_7FFF_0001;
        logic [63:0] b1 = 64'h5555_0100_8000_8000;
        @(negedge clk);
        op_a = a1; op_b = b1; wide_mode = 0; signed_mode = 1; round_mode = 1; low_mode = 0;
        in_valid = 1'b1;
        @(negedge clk);
        op_a = 64'h0000_0002_0000_0001; op_b = 64'h8000_0000_8000_0000;
        wide_mode = 1; signed_mode = 0; round_mode = 1; low_mode = 0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 b2b first valid", {63'd0, out_valid}, 64'd1);
        check("R2 b2b first value", result, 64'h0001_0001_C001_0000);
        @(negedge clk);
        check("R2 b2b second valid", {63'd0, out_valid}, 64'd1);
        check("R2 b2b second value", result, 64'h0000_0001_0000_0001);
        @(negedge clk);
        check("R2 b2b drained", {63'd0, out_valid}, 64'd0);
        check("R9 b2b hold", result, 64'h0000_0001_0000_0001);
    endtask

    // R3 R4 R5 R6 R7: varied patterns in every mode against the model.
    task automatic t_sweep();
        for (int k = 0; k < 48; k++) begin
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] b = {$urandom, $urandom};
            logic w = k[0];
            logic s = k[1];
            logic r = k[2];
            logic l = w & k[3] & k[4];
            run_one("R3-R7 sweep", a, b, w, s, r, l, model(a, b, w, s, r, l));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_narrow_extremes();
        t_narrow_rounding();
        t_wide_high();
        t_low_half();
        t_back_to_back();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule